// File: doc/BRIEF.md
# Bidirectional Cascaded Pixel Sampling Controller

This block collects the display data of one line for a column driver. A start pulse on the pin that the direction input selects arms a column pointer. On each later rising clock edge the pointer writes one pixel, or two neighbouring pixels, into a sampling memory of 108 columns. Each pixel is three colour codes of six bits. A mode input and a port-count input pick one of four row layouts, and each layout leaves a fixed group of middle columns unwritten. When the last column of the row is filled, the block drives a one-clock pulse on the opposite pin to start the next driver in the chain.

A rising edge on the line-latch input copies the whole sampling memory into the hold memory in a single cycle. The hold memory feeds the analog stages, which are outside this block. Each input port has its own polarity bit that stores that port's codes complemented. Direction, mode and port count are treated as static during a row.

Top module: `pixel_sampler`

## Requirements
- R1: After a synchronous active-low reset, both cascade outputs are low, every hold-memory column reads zero and the pointer is idle.
- R2: A start pulse sampled high at a rising clock edge arms the row without capturing; captures happen on the following edges, one step per edge.
- R3: With two-port capture (`one_port` low), port A goes to the column visited first in fill order and port B to the next one, so two columns fill per clock.
- R4: With one-port capture (`one_port` high), only port A is stored and port B has no effect on any column.
- R5: With `dir_fwd` high, `pin_l_i` is the start input and `casc_r_o` the cascade output, and columns fill from index 0 (column 1) upward; `casc_l_o` stays low.
- R6: With `dir_fwd` low, `pin_r_i` is the start input and `casc_l_o` the cascade output, and columns fill from index 107 (column 108) downward; `casc_r_o` stays low.
- R7: The layout code {`mode_sel`, `one_port`} selects 00: no skipped column, 01: column 54 skipped, 10: columns 55 to 58 skipped, 11: columns 54 to 58 skipped (1-based column numbers); skipped columns keep their earlier contents.
- R8: A row takes 54, 107, 52 or 103 capture clocks for layout codes 00, 01, 10 and 11.
- R9: The cascade pulse is high for exactly one clock, in the cycle right after the edge of the final capture.
- R10: After the row completes, the block ignores pixel data until the next start pulse.
- R11: A start pulse while a row is in progress restarts the row at its first column without capturing on that edge.
- R12: When `pol_a` (or `pol_b`) is high, every code taken from that port is stored bitwise complemented.
- R13: On a rising edge of `line_latch`, all 108 columns move from sampling to hold memory in one cycle; the hold memory changes at no other time, including while `line_latch` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | Fill direction and start/cascade pin roles |
| mode_sel | input | 1 | Upper bit of the row layout code |
| one_port | input | 1 | Lower bit of the layout code; high selects one pixel per clock |
| pin_l_i | input | 1 | Left start pin (start when `dir_fwd` is high) |
| pin_r_i | input | 1 | Right start pin (start when `dir_fwd` is low) |
| casc_l_o | output | 1 | Left cascade pulse (used when `dir_fwd` is low) |
| casc_r_o | output | 1 | Right cascade pulse (used when `dir_fwd` is high) |
| pix_a | input | 18 | Port A pixel: three 6-bit colour codes |
| pix_b | input | 18 | Port B pixel: three 6-bit colour codes |
| pol_a | input | 1 | Complement port A codes when high |
| pol_b | input | 1 | Complement port B codes when high |
| line_latch | input | 1 | Rising edge copies sampling memory to hold memory |
| hold_o | output | 1944 | Hold memory, column c at bits [c*18 +: 18] |

## Verification
The bench runs every combination of the two fill directions and the four layout codes, with a pixel pattern that changes with the clock index, so a column written from the wrong clock, port or side of a gap shows up as a mismatch. One-port runs drive busy data on port B to show it is dropped. Clock counts run well past row completion to show late data is ignored. Separate runs set each polarity bit alone, restart a row part way through, and hold `line_latch` high across a whole row to tell edge transfer apart from level transfer. The cascade pulse is checked for its cycle, its width and its pin in every run.

// File: rtl/spc_pkg.sv
// Shared types and helpers for the pixel sampling controller.
// Assumes fewer than 256 columns so a 9-bit signed index covers
// every pointer value including one step past either end.
package spc_pkg;

    localparam int IDX_W = 9;

    typedef logic signed [IDX_W-1:0] idx_t;

    // Row layout code formed as {mode_sel, one_port}.
    typedef enum logic [1:0] {
        LAY_FULL_PAIR = 2'b00,
        LAY_CUT1_ONE  = 2'b01,
        LAY_CUTW_PAIR = 2'b10,
        LAY_CUTW1_ONE = 2'b11
    } layout_e;

    // Inclusive range of skipped column indices (0-based).
    typedef struct packed {
        logic en;
        idx_t lo;
        idx_t hi;
    } gap_t;

    // Work out the skipped range for a layout from the gap base index and width.
    function automatic gap_t gap_for(layout_e lay, int base, int wide);
        gap_t g;
        g.en = 1'b1;
        g.lo = idx_t'(base);
        g.hi = idx_t'(base);
        case (lay)
            LAY_FULL_PAIR: g.en = 1'b0;
            LAY_CUT1_ONE:  g.hi = idx_t'(base);
            LAY_CUTW_PAIR: begin
                g.lo = idx_t'(base + 1);
                g.hi = idx_t'(base + wide);
            end
            default:       g.hi = idx_t'(base + wide);
        endcase
        return g;
    endfunction

endpackage

// File: rtl/spc_pins.sv
// Start/cascade pin role swap.
// Picks which pin acts as the start input and routes the row-done pulse
// to the pin on the opposite side. Combinational only.
module spc_pins (
    input  logic dir_fwd,
    input  logic pin_l_i,
    input  logic pin_r_i,
    input  logic row_done,
    output logic start,
    output logic casc_l_o,
    output logic casc_r_o
);

    // Route start from the leading side and cascade to the trailing side.
    always_comb begin
        start    = dir_fwd ? pin_l_i : pin_r_i;
        casc_r_o = dir_fwd & row_done;
        casc_l_o = ~dir_fwd & row_done;
    end

endmodule

// File: rtl/spc_walker.sv
// Column pointer sequencer.
// A start arms the pointer at the first column in fill order. Each later
// edge issues one write (one or two columns), steps the pointer by the
// port count and jumps over the skipped range. After the final write it
// registers a one-clock row-done pulse and goes idle.
// Assumes the direction, layout and port count stay fixed during a row.
module spc_walker #(
    parameter int NCOL = 108,
    parameter int PW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_fwd,
    input  logic          two_port,
    input  spc_pkg::gap_t gap,
    output logic          wr_en,
    output logic [PW-1:0] col_a,
    output logic [PW-1:0] col_b,
    output logic          row_done
);
    import spc_pkg::*;

    typedef enum logic {ST_IDLE, ST_RUN} walk_e;

    walk_e st_q;
    idx_t  cur_q;
    idx_t  step, raw, adv, partner, first;
    logic  in_gap, last;

    // Next pointer, gap jump and end-of-row detection.
    always_comb begin
        step    = two_port ? idx_t'(2) : idx_t'(1);
        first   = dir_fwd ? idx_t'(0) : idx_t'(NCOL - 1);
        raw     = dir_fwd ? cur_q + step : cur_q - step;
        in_gap  = gap.en && (raw >= gap.lo) && (raw <= gap.hi);
        adv     = raw;
        if (in_gap) begin
            adv = dir_fwd ? gap.hi + idx_t'(1) : gap.lo - idx_t'(1);
        end
        last    = dir_fwd ? (adv >= idx_t'(NCOL)) : (adv < idx_t'(0));
        partner = dir_fwd ? cur_q + idx_t'(1) : cur_q - idx_t'(1);
    end

    // Write strobe and column addresses for the store.
    always_comb begin
        wr_en = (st_q == ST_RUN) && !start;
        col_a = cur_q[PW-1:0];
        col_b = partner[PW-1:0];
    end

    // Pointer state: start has priority and restarts the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_q    <= '0;
            row_done <= 1'b0;
        end else begin
            row_done <= 1'b0;
            if (start) begin
                st_q  <= ST_RUN;
                cur_q <= first;
            end else if (st_q == ST_RUN) begin
                if (last) begin
                    st_q     <= ST_IDLE;
                    row_done <= 1'b1;
                end else begin
                    cur_q <= adv;
                end
            end
        end
    end

endmodule

// File: rtl/spc_store.sv
// Sampling and hold memories.
// Each column has its own sampling register written when its index matches
// the port A or port B address, and a hold register loaded from it on a
// rising edge of the line latch. Polarity bits complement the port codes.
module spc_store #(
    parameter int NCOL = 108,
    parameter int CW   = 18,
    parameter int PW   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               two_port,
    input  logic [PW-1:0]      col_a,
    input  logic [PW-1:0]      col_b,
    input  logic [CW-1:0]      pix_a,
    input  logic [CW-1:0]      pix_b,
    input  logic               pol_a,
    input  logic               pol_b,
    input  logic               line_latch,
    output logic [NCOL*CW-1:0] hold_o
);

    logic          latch_q;
    logic          latch_rise;
    logic [CW-1:0] data_a, data_b;

    // Polarity-adjusted port data and latch edge.
    always_comb begin
        data_a     = pix_a ^ {CW{pol_a}};
        data_b     = pix_b ^ {CW{pol_b}};
        latch_rise = line_latch && !latch_q;
    end

    // Previous latch level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= 1'b0;
        else        latch_q <= line_latch;
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [CW-1:0] samp_q;
        logic [CW-1:0] hold_q;

        // Sampling register: port A address wins, port B only in pair mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                samp_q <= '0;
            end else if (wr_en && col_a == PW'(c)) begin
                samp_q <= data_a;
            end else if (wr_en && two_port && col_b == PW'(c)) begin
                samp_q <= data_b;
            end
        end

        // Hold register: parallel load on the latch rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n)          hold_q <= '0;
            else if (latch_rise) hold_q <= samp_q;
        end

        assign hold_o[c*CW +: CW] = hold_q;
    end

endmodule

// File: rtl/pixel_sampler.sv
// Top of the pixel sampling controller.
// Decodes the layout code into a port count and a skipped-column range,
// then ties the pin swap, the pointer sequencer and the memories together.
// Assumes dir_fwd, mode_sel and one_port are static while a row runs.
module pixel_sampler #(
    parameter int NCOL     = 108,
    parameter int DW       = 6,
    parameter int GAP_BASE = 53,
    parameter int GAP_WIDE = 4,
    localparam int CW      = 3 * DW,
    localparam int PW      = $clog2(NCOL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_fwd,
    input  logic               mode_sel,
    input  logic               one_port,
    input  logic               pin_l_i,
    input  logic               pin_r_i,
    output logic               casc_l_o,
    output logic               casc_r_o,
    input  logic [CW-1:0]      pix_a,
    input  logic [CW-1:0]      pix_b,
    input  logic               pol_a,
    input  logic               pol_b,
    input  logic               line_latch,
    output logic [NCOL*CW-1:0] hold_o
);
    import spc_pkg::*;

    layout_e       lay;
    gap_t          gap;
    logic          two_port;
    logic          start, row_done, wr_en;
    logic [PW-1:0] col_a, col_b;

    // Layout decode from the static mode inputs.
    always_comb begin
        lay      = layout_e'({mode_sel, one_port});
        gap      = gap_for(lay, GAP_BASE, GAP_WIDE);
        two_port = !one_port;
    end

    spc_pins u_pins (
        .dir_fwd  (dir_fwd),
        .pin_l_i  (pin_l_i),
        .pin_r_i  (pin_r_i),
        .row_done (row_done),
        .start    (start),
        .casc_l_o (casc_l_o),
        .casc_r_o (casc_r_o)
    );

    spc_walker #(.NCOL(NCOL), .PW(PW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dir_fwd  (dir_fwd),
        .two_port (two_port),
        .gap      (gap),
        .wr_en    (wr_en),
        .col_a    (col_a),
        .col_b    (col_b),
        .row_done (row_done)
    );

    spc_store #(.NCOL(NCOL), .CW(CW), .PW(PW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .two_port   (two_port),
        .col_a      (col_a),
        .col_b      (col_b),
        .pix_a      (pix_a),
        .pix_b      (pix_b),
        .pol_a      (pol_a),
        .pol_b      (pol_b),
        .line_latch (line_latch),
        .hold_o     (hold_o)
    );

endmodule

// File: rtl/spc_checker.sv
// Port-level checker for pixel_sampler, attached by bind.
// Counts clocks from each start pulse and compares the cascade pulse with
// the row length expected for the current layout; watches the hold memory
// for changes outside a latch rising edge.
module spc_checker #(
    parameter int NCOL     = 108,
    parameter int CW       = 18,
    parameter int GAP_WIDE = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dir_fwd,
    input logic               mode_sel,
    input logic               one_port,
    input logic               pin_l_i,
    input logic               pin_r_i,
    input logic               casc_l_o,
    input logic               casc_r_o,
    input logic               line_latch,
    input logic [NCOL*CW-1:0] hold_o
);

    int   gap_n, nclk, ck_cnt;
    logic ck_run, ck_latch_q, casc_any, st_seen;

    // Expected row length and observed start/cascade.
    always_comb begin
        case ({mode_sel, one_port})
            2'b00:   gap_n = 0;
            2'b01:   gap_n = 1;
            2'b10:   gap_n = GAP_WIDE;
            default: gap_n = GAP_WIDE + 1;
        endcase
        nclk     = (NCOL - gap_n) / (one_port ? 1 : 2);
        casc_any = casc_l_o || casc_r_o;
        st_seen  = dir_fwd ? pin_l_i : pin_r_i;
    end

    // Clock counter since the last start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_run     <= 1'b0;
            ck_cnt     <= 0;
            ck_latch_q <= 1'b0;
        end else begin
            ck_latch_q <= line_latch;
            if (st_seen) begin
                ck_run <= 1'b1;
                ck_cnt <= 1;
            end else if (ck_run) begin
                if (ck_cnt == nclk + 1) ck_run <= 1'b0;
                else                    ck_cnt <= ck_cnt + 1;
            end
        end
    end

    AST_CASC_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        casc_any |=> !casc_any); // R9
    AST_CASC_LEFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fwd |-> !casc_l_o); // R5
    AST_CASC_RIGHT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_fwd |-> !casc_r_o); // R6
    AST_CASC_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        casc_any |-> (ck_run && ck_cnt == nclk + 1)); // R8
    AST_ROW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_run && ck_cnt == nclk + 1) |-> casc_any); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_latch && !ck_latch_q) |=> $stable(hold_o)); // R13

endmodule

bind pixel_sampler spc_checker #(
    .NCOL     (NCOL),
    .CW       (CW),
    .GAP_WIDE (GAP_WIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_fwd    (dir_fwd),
    .mode_sel   (mode_sel),
    .one_port   (one_port),
    .pin_l_i    (pin_l_i),
    .pin_r_i    (pin_r_i),
    .casc_l_o   (casc_l_o),
    .casc_r_o   (casc_r_o),
    .line_latch (line_latch),
    .hold_o     (hold_o)
);

// File: tb/sim_pixel_sampler.sv
`timescale 1ns/1ps
module sim_pixel_sampler;

    localparam int NCOL = 108;
    localparam int CW   = 18;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               dir_fwd = 1'b1, mode_sel = 1'b0, one_port = 1'b0;
    logic               pin_l_i = 1'b0, pin_r_i = 1'b0;
    logic               casc_l_o, casc_r_o;
    logic [CW-1:0]      pix_a = '0, pix_b = '0;
    logic               pol_a = 1'b0, pol_b = 1'b0;
    logic               line_latch = 1'b0;
    logic [NCOL*CW-1:0] hold_o;

    int            n_chk = 0, n_fail = 0;
    bit            done = 0;
    logic [CW-1:0] smem [NCOL];
    logic [CW-1:0] hsnap [NCOL];
    int            lst [NCOL];
    int            len;

    always #2.5 clk = ~clk;

    pixel_sampler u0 (
        .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .mode_sel(mode_sel),
        .one_port(one_port), .pin_l_i(pin_l_i), .pin_r_i(pin_r_i),
        .casc_l_o(casc_l_o), .casc_r_o(casc_r_o), .pix_a(pix_a), .pix_b(pix_b),
        .pol_a(pol_a), .pol_b(pol_b), .line_latch(line_latch), .hold_o(hold_o)
    );

    function automatic logic [CW-1:0] pat_a(int k);
        return {6'(k * 5 + 2), 6'(k * 3 + 1), 6'(k)};
    endfunction

    function automatic logic [CW-1:0] pat_b(int k);
        return {6'(k + 40), 6'(k * 7 + 3), 6'(k + 9)};
    endfunction

    // 1-based column skipped for layout {ms, op}
    function automatic bit skipped(bit ms, bit op, int col);
        if (!ms && op)  return col == 54;
        if (ms && !op)  return col >= 55 && col <= 58;
        if (ms && op)   return col >= 54 && col <= 58;
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare hold output against a reference image column by column.
    task automatic cmp_hold(input logic [CW-1:0] ref_img [NCOL], string req);
        int bad = 0, first_bad = -1;
        for (int c = 0; c < NCOL; c++) begin
            if (hold_o[c*CW +: CW] !== ref_img[c]) begin
                bad++;
                if (first_bad < 0) first_bad = c;
            end
        end
        check(bad == 0, req, "hold columns mismatching (first index)", first_bad, -1);
    endtask

    task automatic pulse_latch();
        @(negedge clk) line_latch = 1'b1;
        @(negedge clk) line_latch = 1'b0;
    endtask

    task automatic run_row(bit fwd, bit ms, bit op, bit pa, bit pb, int restart_at, string req);
        int p, n, idx, casc_exp, hits, first_hit, wrong;
        bit act, st;
        dir_fwd = fwd; mode_sel = ms; one_port = op; pol_a = pa; pol_b = pb;
        len = 0;
        for (int c = 1; c <= NCOL; c++) if (!skipped(ms, op, c)) begin lst[len] = c - 1; len++; end
        if (!fwd) for (int i = 0; i < len / 2; i++) begin
            int t = lst[i]; lst[i] = lst[len-1-i]; lst[len-1-i] = t;
        end
        p = op ? 1 : 2;
        n = len / p;
        @(negedge clk);
        if (fwd) pin_l_i = 1'b1; else pin_r_i = 1'b1;
        @(negedge clk);
        pin_l_i = 1'b0; pin_r_i = 1'b0;
        idx = 0; act = 1; casc_exp = -1; hits = 0; first_hit = -1; wrong = 0;
        for (int k = 1; k <= 170; k++) begin
            pix_a = pat_a(k);
            pix_b = pat_b(k);
            st = (k == restart_at);
            if (st) begin if (fwd) pin_l_i = 1'b1; else pin_r_i = 1'b1; end
            if (st) begin
                idx = 0; act = 1;
            end else if (act) begin
                smem[lst[idx*p]] = pix_a ^ {CW{pa}};
                if (p == 2) smem[lst[idx*p+1]] = pix_b ^ {CW{pb}};
                idx++;
                if (idx == n) begin act = 0; casc_exp = k; end
            end
            @(negedge clk);
            pin_l_i = 1'b0; pin_r_i = 1'b0;
            if (fwd ? casc_r_o : casc_l_o) begin
                hits++;
                if (first_hit < 0) first_hit = k;
            end
            if (fwd ? casc_l_o : casc_r_o) wrong++;
        end
        check(first_hit == casc_exp, {req, " R8"}, "cascade cycle", first_hit, casc_exp);
        check(hits == 1, {req, " R9"}, "cascade width", hits, 1);
        check(wrong == 0, fwd ? "R5" : "R6", "pulses on start-side pin", wrong, 0);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCOL; c++) smem[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(casc_l_o == 1'b0 && casc_r_o == 1'b0, "R1", "cascade after reset",
              int'({casc_l_o, casc_r_o}), 0);
        cmp_hold(smem, "R1");

        // Sweep all directions and layouts: R2 R3 R4 R5 R6 R7 R10
        for (int d = 1; d >= 0; d--) begin
            for (int lay = 0; lay < 4; lay++) begin
                bit ms = lay[1], op = lay[0];
                run_row(d[0], ms, op, 1'b0, 1'b0, 0, op ? "R4 R7" : "R3 R7");
                pulse_latch();
                cmp_hold(smem, op ? "R2 R4 R7 R10" : "R2 R3 R7 R10");
            end
        end

        // R12: polarity per port
        run_row(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R12");
        pulse_latch();
        cmp_hold(smem, "R12 port A complement");
        run_row(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R12");
        pulse_latch();
        cmp_hold(smem, "R12 port B complement");

        // R11: restart in the middle of a row
        run_row(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10, "R11");
        pulse_latch();
        cmp_hold(smem, "R11");
        run_row(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 37, "R11");
        pulse_latch();
        cmp_hold(smem, "R11 reverse");

        // R13: latch held high across a row loads only once
        @(negedge clk) line_latch = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NCOL; c++) hsnap[c] = smem[c];
        cmp_hold(hsnap, "R13 load on rise");
        run_row(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R13");
        cmp_hold(hsnap, "R13 level latch ignored");
        @(negedge clk) line_latch = 1'b0;
        run_row(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0, "R13");
        cmp_hold(hsnap, "R13 no latch edge");
        pulse_latch();
        cmp_hold(smem, "R13 new edge");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule